// File: doc/BRIEF.md
# Three-Wire Tuner Control Port

This block is the slave side of a three-wire control link for a tuner frequency synthesizer. A host drives a chip enable, a clock and a data line. It reads status back on one open-drain line, which this block models as a single "pull low" control. All three host inputs are brought into a fast core clock through two-flop synchronizers. Clock edges are found on the synchronized copy.

While enable is low, the host shifts in an 8-bit address, MSB first, on rising clock edges. When enable rises, the last eight bits captured choose a mode: write control word A, write control word B, or read status. A write shifts in 24 data bits, MSB first. The word takes effect only when enable falls, and only if all 24 bits arrived. A read shifts out a 23-bit status frame, one bit per falling clock edge. The frame holds the two I/O pin levels captured on entry, the lock flag and a 20-bit count value.

Between transfers the data-out line acts as a monitor. Three bits of control word B choose what it shows: the lock state, an end-of-count flag, or one I/O pin level.

Control word B fields:

| Field | Bits | Meaning |
|---|---|---|
| Monitor select | [2:0] | Chooses the idle data-out source |
| Pin 1 direction | [3] | 1 = output |
| Pin 2 direction | [4] | 1 = output |
| Port drive | [10:5] | Port drive bits |
| Count run | [11] | Count run flag |

Top module: `sctl_serial_if`

## Requirements
- R1: The address byte latched at enable rise selects the mode: 0x82 writes word A, 0x92 writes word B, 0xA2 reads status. Any other code starts no mode, leaves both words unchanged and leaves data-out open.
- R2: In a write mode, 24 bits sampled on rising clock edges, MSB first, are copied into the selected word when enable falls. The other word is unchanged.
- R3: If enable falls after fewer than 24 data bits, both words keep their previous values. Bits after the 24th are ignored.
- R4: In read mode, data-out presents the status frame MSB first: pin 2 level, pin 1 level, lock flag, then count[19:0]. The first bit is valid once enable is high, and each later falling clock edge advances one bit. A 1 bit is open and a 0 bit pulls low. After the frame, data-out stays open.
- R5: The pin levels in the read frame are captured at read entry, whatever each pin's direction. Later pin changes during the read do not appear.
- R6: While enable is high in a write mode, data-out is open whatever the monitor selection.
- R7: With enable low, monitor select word B[2:0] sets data-out as follows:
  - 000, 011, 100 and 111 leave it open.
  - 001 pulls low when the lock input is 0.
  - 010 pulls low while the end-of-count flag is set.
  - 101 follows the pin 1 level.
  - 110 follows the pin 2 level.
- R8: If pin 1 or pin 2 is selected for monitoring but its direction bit (word B[3] or B[4]) is 1 (output), data-out stays open.
- R9: The end-of-count flag is set by a count-done pulse. It is cleared when a word B commit raises bit 11 from 0 to 1, and it is held clear while enable is high.
- R10: After reset, word A is 0x100000 (crystal select bit 20 set), word B is 0 and data-out is open.
- R11: The interface works with a clock that idles low and with one that idles high. When the clock is high as enable rises, the first falling edge of a read does not advance the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-on reset |
| en_i | input | 1 | Serial chip enable (asynchronous) |
| sck_i | input | 1 | Serial clock (asynchronous) |
| sdi_i | input | 1 | Serial data in (asynchronous) |
| lock_i | input | 1 | 1 when the loop is locked |
| cnt_done_i | input | 1 | One-cycle pulse at the end of a measurement period |
| cnt_value_i | input | 20 | Current count result |
| io1_pin_i | input | 1 | Level seen on I/O pin 1 |
| io2_pin_i | input | 1 | Level seen on I/O pin 2 |
| sdo_low_o | output | 1 | 1 pulls the open-drain data-out low, 0 leaves it open |
| ctrl_a_o | output | 24 | Control word A |
| ctrl_b_o | output | 24 | Control word B |

## Verification
On every cycle, the assertions check four things:
- the mode is held only while enable is high;
- the data-bit counter never passes 24;
- the control words move only on an enable fall;
- a read frame shifts by exactly one bit per counted falling edge.

They also check that data-out is open during writes and for the open monitor codes, and that the end-of-count flag is clear during a transfer.

Only the bench scenarios can show the rest. These cover the exact bit order of frames, discarding a short word, capturing the pin levels at read entry, each monitor code against real pin and lock levels, and the same transfers under an idle-high clock.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    typedef enum logic [1:0] {
        M_NONE = 2'd0,
        M_WR_A = 2'd1,
        M_WR_B = 2'd2,
        M_RD   = 2'd3
    } xfer_mode_e;

    localparam logic [7:0] ADDR_WR_A = 8'h82;
    localparam logic [7:0] ADDR_WR_B = 8'h92;
    localparam logic [7:0] ADDR_RD   = 8'hA2;

    // field positions inside control word B
    localparam int MON_LSB  = 0;
    localparam int DIR1_BIT = 3;
    localparam int DIR2_BIT = 4;
    localparam int RUN_BIT  = 11;

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sctl_monitor.sv
module sctl_monitor (
    input  logic [2:0] sel,
    input  logic       locked,
    input  logic       eoc,
    input  logic       io1_lvl,
    input  logic       io2_lvl,
    input  logic       io1_out,
    input  logic       io2_out,
    output logic       pull_low
);
    always_comb begin
        unique case (sel)
            3'b001:  pull_low = ~locked;
            3'b010:  pull_low = eoc;
            3'b101:  pull_low = io1_out ? 1'b0 : ~io1_lvl;
            3'b110:  pull_low = io2_out ? 1'b0 : ~io2_lvl;
            default: pull_low = 1'b0;
        endcase
    end
endmodule

// File: rtl/sctl_serial_if.sv
module sctl_serial_if
    import sctl_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int ADDR_W      = 8,
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2,
    parameter int XTAL_BIT    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic              lock_i,
    input  logic              cnt_done_i,
    input  logic [CNT_W-1:0]  cnt_value_i,
    input  logic              io1_pin_i,
    input  logic              io2_pin_i,
    output logic              sdo_low_o,
    output logic [DATA_W-1:0] ctrl_a_o,
    output logic [DATA_W-1:0] ctrl_b_o
);
    localparam int STAT_W = CNT_W + 3;
    localparam int BCNT_W = $clog2(DATA_W + 1);
    localparam logic [BCNT_W-1:0] NB_FULL = BCNT_W'(DATA_W);
    localparam logic [DATA_W-1:0] A_RST   = DATA_W'(1) << XTAL_BIT;

    typedef struct packed {
        logic              en_p;
        logic              sck_p;
        xfer_mode_e        mode;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] sh;
        logic [BCNT_W-1:0] nb;
        logic [STAT_W-1:0] rd;
        logic              skip;
        logic              eoc;
        logic [DATA_W-1:0] wa;
        logic [DATA_W-1:0] wb;
    } st_t;

    st_t q, d;
    logic en_s, sck_s, sdi_s, io1_s, io2_s;
    logic en_rise, en_fall, sck_rise, sck_fall;
    logic mon_low;

    sctl_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({en_i, sck_i, sdi_i, io1_pin_i, io2_pin_i}),
        .q     ({en_s, sck_s, sdi_s, io1_s, io2_s})
    );

    sctl_monitor u_mon (
        .sel      (q.wb[MON_LSB +: 3]),
        .locked   (lock_i),
        .eoc      (q.eoc),
        .io1_lvl  (io1_s),
        .io2_lvl  (io2_s),
        .io1_out  (q.wb[DIR1_BIT]),
        .io2_out  (q.wb[DIR2_BIT]),
        .pull_low (mon_low)
    );

    assign en_rise  =  en_s  & ~q.en_p;
    assign en_fall  = ~en_s  &  q.en_p;
    assign sck_rise =  sck_s & ~q.sck_p;
    assign sck_fall = ~sck_s &  q.sck_p;

    always_comb begin
        d       = q;
        d.en_p  = en_s;
        d.sck_p = sck_s;

        if (!en_s && sck_rise)
            d.addr = {q.addr[ADDR_W-2:0], sdi_s};

        if (en_rise) begin
            d.nb   = '0;
            d.skip = sck_s;
            unique case (q.addr)
                ADDR_WR_A: d.mode = M_WR_A;
                ADDR_WR_B: d.mode = M_WR_B;
                ADDR_RD: begin
                    d.mode = M_RD;
                    d.rd   = {io2_s, io1_s, lock_i, cnt_value_i};
                end
                default:   d.mode = M_NONE;
            endcase
        end else if (en_s) begin
            if (sck_rise && (q.mode == M_WR_A || q.mode == M_WR_B) && q.nb < NB_FULL) begin
                d.sh = {q.sh[DATA_W-2:0], sdi_s};
                d.nb = q.nb + BCNT_W'(1);
            end
            if (sck_fall && q.mode == M_RD) begin
                if (q.skip) d.skip = 1'b0;
                else        d.rd   = {q.rd[STAT_W-2:0], 1'b1};
            end
        end

        if (cnt_done_i) d.eoc = 1'b1;

        if (en_fall) begin
            d.mode = M_NONE;
            if (q.nb == NB_FULL) begin
                if (q.mode == M_WR_A) d.wa = q.sh;
                if (q.mode == M_WR_B) begin
                    d.wb = q.sh;
                    if (q.sh[RUN_BIT] && !q.wb[RUN_BIT]) d.eoc = 1'b0;
                end
            end
        end

        if (en_s) d.eoc = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mode <= M_NONE;
            q.wa   <= A_RST;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (en_s) sdo_low_o = (q.mode == M_RD) ? ~q.rd[STAT_W-1] : 1'b0;
        else      sdo_low_o = mon_low;
    end

    assign ctrl_a_o = q.wa;
    assign ctrl_b_o = q.wb;

    // R1
    mode_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode != M_NONE) |-> q.en_p);

    // R3
    bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.nb <= NB_FULL);

    // R2
    commit_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_fall |=> ($stable(ctrl_a_o) && $stable(ctrl_b_o)));

    // R4
    read_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == M_RD && en_s && !en_rise && sck_fall && !q.skip)
        |=> (q.rd[STAT_W-1:1] == $past(q.rd[STAT_W-2:0])));

    // R6
    write_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && (q.mode == M_WR_A || q.mode == M_WR_B)) |-> !sdo_low_o);

    // R7
    idle_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_s && (ctrl_b_o[2:0] == 3'b000 || ctrl_b_o[2:0] == 3'b011 ||
                   ctrl_b_o[2:0] == 3'b100 || ctrl_b_o[2:0] == 3'b111)) |-> !sdo_low_o);

    // R9
    eoc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_s |=> !q.eoc);
endmodule

// File: tb/sim_sctl_serial_if.sv
module sim_sctl_serial_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0, sck_i = 1'b0, sdi_i = 1'b0;
    logic        lock_i = 1'b1, cnt_done_i = 1'b0;
    logic [19:0] cnt_value_i = '0;
    logic        io1_pin_i = 1'b0, io2_pin_i = 1'b0;
    logic        sdo_low_o;
    logic [23:0] ctrl_a_o, ctrl_b_o;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sctl_serial_if u0 (.*);

    // {addr, data, expected A, expected B}
    localparam logic [79:0] VEC [5] = '{
        {8'h82, 24'h123456, 24'h123456, 24'h000000},
        {8'h92, 24'h000A01, 24'h123456, 24'h000A01},
        {8'h55, 24'hFFFFFF, 24'h123456, 24'h000A01},
        {8'h82, 24'hABCDEF, 24'hABCDEF, 24'h000A01},
        {8'h92, 24'h000000, 24'hABCDEF, 24'h000000}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_bit(input logic b, input bit hi);
        if (hi) begin
            sck_i = 1'b0; sdi_i = b; tick(4); sck_i = 1'b1; tick(4);
        end else begin
            sdi_i = b; tick(2); sck_i = 1'b1; tick(4); sck_i = 1'b0; tick(4);
        end
    endtask

    task automatic send_addr(input logic [7:0] a, input bit hi);
        en_i = 1'b0; sck_i = hi; tick(4);
        for (int i = 7; i >= 0; i--) put_bit(a[i], hi);
        tick(4);
    endtask

    task automatic wr(input logic [7:0] a, input logic [23:0] v, input int nbits, input bit hi);
        send_addr(a, hi);
        en_i = 1'b1; tick(6);
        for (int i = 0; i < nbits; i++) put_bit(v[23-i], hi);
        tick(4); en_i = 1'b0; tick(8);
    endtask

    task automatic rd(input bit hi, input bit flip_io, output logic [23:0] got);
        send_addr(8'hA2, hi);
        en_i = 1'b1; tick(6);
        if (flip_io) begin io1_pin_i = ~io1_pin_i; io2_pin_i = ~io2_pin_i; end
        for (int i = 23; i >= 0; i--) begin
            if (hi) begin
                sck_i = 1'b0; tick(6); got[i] = ~sdo_low_o; sck_i = 1'b1; tick(4);
            end else begin
                got[i] = ~sdo_low_o; sck_i = 1'b1; tick(4); sck_i = 1'b0; tick(6);
            end
        end
        en_i = 1'b0; tick(8);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [23:0] got;
        logic        exp_low;
        tick(5); rst_n = 1'b1; tick(4);

        // R10 reset state
        check("R10 word A", ctrl_a_o, 24'h100000);
        check("R10 word B", ctrl_b_o, 24'h0);
        check("R10 sdo open", sdo_low_o, 1'b0);

        // R1 R2 vector table
        foreach (VEC[k]) begin
            wr(VEC[k][79:72], VEC[k][71:48], 24, 1'b0);
            check("R1 R2 vec word A", ctrl_a_o, VEC[k][47:24]);
            check("R1 R2 vec word B", ctrl_b_o, VEC[k][23:0]);
        end
        check("R1 bad addr sdo open", sdo_low_o, 1'b0);

        // R3 short word discarded
        wr(8'h82, 24'h0F0F0F, 20, 1'b0);
        check("R3 short word A", ctrl_a_o, 24'hABCDEF);

        // R4 R5 read with pin 1 as output, pins flipped after entry
        wr(8'h92, 24'h000008, 24, 1'b0);
        io1_pin_i = 1'b1; io2_pin_i = 1'b0; lock_i = 1'b1; cnt_value_i = 20'h5A3C1;
        tick(4);
        rd(1'b0, 1'b1, got);
        check("R4 R5 read frame", got, {1'b0, 1'b1, 1'b1, 20'h5A3C1, 1'b1});

        // R11 idle-high clock: read and write
        io1_pin_i = 1'b0; io2_pin_i = 1'b1; lock_i = 1'b0; cnt_value_i = 20'h80001;
        tick(4);
        rd(1'b1, 1'b0, got);
        check("R11 R4 idle-high read", got, {1'b1, 1'b0, 1'b0, 20'h80001, 1'b1});
        wr(8'h82, 24'h3C5AA5, 24, 1'b1);
        check("R11 idle-high write", ctrl_a_o, 24'h3C5AA5);
        sck_i = 1'b0; tick(4);

        // R7 each monitor code: lock=0, pin1=0, pin2=1, end-of-count clear
        for (int c = 0; c < 8; c++) begin
            wr(8'h92, 24'(c), 24, 1'b0);
            tick(4);
            exp_low = (c == 1) || (c == 5);
            check("R7 monitor code", sdo_low_o, exp_low);
        end

        // R6 data-out open during a write even with unlock monitor active
        wr(8'h92, 24'h000001, 24, 1'b0);
        check("R7 unlock low", sdo_low_o, 1'b1);
        send_addr(8'h82, 1'b0);
        en_i = 1'b1; tick(6);
        check("R6 write open", sdo_low_o, 1'b0);
        for (int i = 0; i < 24; i++) put_bit(1'b0, 1'b0);
        tick(4); en_i = 1'b0; tick(8);
        check("R6 commit after", ctrl_a_o, 24'h0);

        // R8 pin monitored while configured as output
        wr(8'h92, 24'h00000D, 24, 1'b0);
        tick(4);
        check("R8 pin1 output open", sdo_low_o, 1'b0);
        wr(8'h92, 24'h000016, 24, 1'b0);
        io2_pin_i = 1'b0; tick(4);
        check("R8 pin2 output open", sdo_low_o, 1'b0);

        // R9 end-of-count flag
        wr(8'h92, 24'h000802, 24, 1'b0);
        tick(2);
        check("R9 open after start", sdo_low_o, 1'b0);
        cnt_done_i = 1'b1; tick(1); cnt_done_i = 1'b0; tick(2);
        check("R9 low at end", sdo_low_o, 1'b1);
        wr(8'h92, 24'h000802, 24, 1'b0);
        check("R9 open after transfer", sdo_low_o, 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule